// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host offers one request at a time, either a read or a write, over a valid/ready handshake. The controller then produces the active-low chip-select, output-enable and write-strobe waveforms for the memory, and it holds the memory address steady while they are active. Read data returns to the host on a single-cycle valid strobe. The memory data bus is bidirectional, so it appears here as three signals: a driven value, a drive enable and a sampled value.

The phase lengths are counted in clock cycles. Each count is derived at elaboration from picosecond timing parameters and the clock period: the ceiling of the limit divided by the period, with a floor of one cycle. One controller therefore covers every speed grade. A read phase lasts the largest of the address-access, output-enable-access and minimum-cycle counts. A write phase lasts the largest of the write-pulse, data-setup and minimum-cycle counts. After any read, a turnaround guard keeps the controller from driving the bus until the memory has had time to let go of it.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, chip select, output enable and write strobe are high, the data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: Whenever `req_ready` is high, the memory is deselected: all three strobes are high and the bus is not driven.
- R3: A read holds chip select and output enable low and write strobe high for exactly RD_LEN consecutive cycles, where RD_LEN = max(access, output-enable access, cycle-time counts); with the defaults at a 4 ns clock this is 3 cycles. `rsp_valid` rises RD_LEN+1 cycles after the cycle in which the request was accepted.
- R4: The read byte is sampled from the bus at the end of the last read-phase cycle. It is presented on `rsp_rdata` during a one-cycle `rsp_valid` pulse. An address that was never written reads as 0x00 in the bench memory.
- R5: A write holds chip select and write strobe low, with output enable high, for exactly WR_LEN consecutive cycles, where WR_LEN = max(write-pulse, data-setup, cycle-time counts); this is 3 cycles with the defaults. The memory address does not change while chip select is low.
- R6: The data drive enable is high only while both chip select and write strobe are low and output enable is high. It falls on the same edge that raises the write strobe, and it never overlaps a cycle in which the memory is driving the bus.
- R7: Write data is stable on the bus for the whole write phase, which is at least the data-setup count before the write strobe rises.
- R8: Two accepted requests are at least RC+1 cycles apart, where RC is the cycle-time count.
- R9: After the cycle in which output enable last went high, the first cycle that drives write data is no earlier than TURN cycles later, where TURN is the bus-release count (3 with the defaults). A write that follows a write, or that follows a long enough idle period, begins driving in the cycle right after it is accepted.
- R10: A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is low in the cycle after acceptance and stays low until the phase completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | 8 | Read byte |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_out | output | 8 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bench memory model returns the inverted byte until access time has elapsed, keeps driving the bus for the release time after output enable rises, and commits a write only when the strobe ends. An early sample, a short pulse or a bus collision therefore each show up as a different symptom. Isolated writes and reads at both address extremes, using 0x00, 0xFF and alternating patterns, test storage and the phase lengths. A run of writes followed by reads in reverse order tests address hold. Read-then-write pairs and back-to-back writes separate the turnaround delay from the normal one-cycle write start. Reads of addresses that were never written separate stale capture from real data.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state type and elaboration-time helpers for the
// asynchronous SRAM controller. Assumes integer picosecond inputs.
package sram_ctl_pkg;

    // Sequencer states; the encoding is internal only.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_WR_HOLD = 2'd2,
        ST_WRITE   = 2'd3
    } seq_state_t;

    // Ceiling of a time limit over the clock period, at least one cycle.
    function automatic int cyc_ceil(input int limit_ps, input int period_ps);
        int c;
        c = (limit_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Largest of three counts.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module: down-counter that times one strobe phase.
// Loaded with (length - 1) on the edge entering a phase; done is high in
// the phase's final cycle. Assumes load is never asserted while counting
// within the same phase.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_turn_guard.sv
// Module: bus-turnaround guard.
// When a read phase ends, it loads the release count. The count then
// falls by one each cycle. clear is high once the next edge lies at least
// TURN_CYC edges past the edge that raised output enable, so a write
// phase entered on that edge cannot collide with the memory still
// driving the bus.
module sram_turn_guard #(
    parameter int CNT_W    = 4,
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_end,
    output logic clear
);

    localparam logic [CNT_W-1:0] TURN_V = CNT_W'(TURN_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Restart the release window at each read end, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rd_end) begin
            cnt_q <= TURN_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign clear = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/sram_seq_fsm.sv
// Module: transaction sequencer.
// Accepts one request while idle. A read goes straight to the read phase.
// A write goes to the write phase, first waiting in a hold state while the
// turnaround guard is not yet clear. At each phase entry it loads the
// phase timer and returns to idle in the last phase cycle. It also
// exports the next state so that pin registers can follow it without
// decode glitches.
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int RD_LEN = 3,
    parameter int WR_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_done,
    input  logic             turn_clear,
    output seq_state_t       nxt_state,
    output logic             accept,
    output logic             ld_phase,
    output logic [CNT_W-1:0] ld_val,
    output logic             rd_done
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_LEN - 1);

    seq_state_t state_q;

    // Next-state selection for the single-beat sequence.
    always_comb begin
        nxt_state = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)      nxt_state = ST_READ;
                    else if (turn_clear) nxt_state = ST_WRITE;
                    else                 nxt_state = ST_WR_HOLD;
                end
            end
            ST_READ:    if (phase_done) nxt_state = ST_IDLE;
            ST_WR_HOLD: if (turn_clear) nxt_state = ST_WRITE;
            ST_WRITE:   if (phase_done) nxt_state = ST_IDLE;
            default:    nxt_state = ST_IDLE;
        endcase
    end

    // Phase-entry detection, timer load value and read completion.
    always_comb begin
        accept   = (state_q == ST_IDLE) && req_valid;
        rd_done  = (state_q == ST_READ) && phase_done;
        ld_phase = ((nxt_state == ST_READ)  && (state_q != ST_READ)) ||
                   ((nxt_state == ST_WRITE) && (state_q != ST_WRITE));
        ld_val   = (nxt_state == ST_READ) ? RD_LOAD : WR_LOAD;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt_state;
    end

endmodule

// File: rtl/sram_pin_drv.sv
// Module: registered memory strobes, bus drive enable and host ready.
// Every output is a flop loaded from the sequencer's next state, so the
// write strobe and the drive enable change on the same edge. Reset leaves
// the memory deselected and the bus released.
module sram_pin_drv
    import sram_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t nxt_state,
    output logic       ce_n,
    output logic       oe_n,
    output logic       we_n,
    output logic       dq_oe,
    output logic       ready
);

    // Strobe levels follow the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            ready <= 1'b1;
        end else begin
            ce_n  <= !((nxt_state == ST_READ) || (nxt_state == ST_WRITE));
            oe_n  <= (nxt_state != ST_READ);
            we_n  <= (nxt_state != ST_WRITE);
            dq_oe <= (nxt_state == ST_WRITE);
            ready <= (nxt_state == ST_IDLE);
        end
    end

endmodule

// File: rtl/sram_datapath.sv
// Module: address, write-data and read-data registers.
// The address and write byte are loaded only on acceptance, so they stay
// fixed through the whole transaction and afterwards (zero hold). The bus
// value is captured on the last read cycle and flagged for one cycle.
module sram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Latch the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            dq_out <= '0;
        end else if (accept) begin
            addr   <= req_addr;
            dq_out <= req_wdata;
        end
    end

    // Sample the bus at the read phase end and raise a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Module: top of the asynchronous SRAM controller.
// It converts picosecond limits into cycle counts, and it wires up the
// sequencer, phase timer, turnaround guard, pin registers and datapath.
// Assumptions: one transaction in flight; the host keeps its request
// fields steady while req_valid is high and not yet accepted.
module sram_async_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int CLK_PS     = 4000,
    parameter int T_AA_PS    = 12000,
    parameter int T_OE_PS    = 6000,
    parameter int T_WP_PS    = 10000,
    parameter int T_DS_PS    = 7000,
    parameter int T_HZ_PS    = 9000,
    parameter int T_RC_PS    = 12000,
    parameter int RD_ACC_CYC = cyc_ceil(T_AA_PS, CLK_PS),
    parameter int OE_ACC_CYC = cyc_ceil(T_OE_PS, CLK_PS),
    parameter int WP_CYC     = cyc_ceil(T_WP_PS, CLK_PS),
    parameter int DS_CYC     = cyc_ceil(T_DS_PS, CLK_PS),
    parameter int TURN_CYC   = cyc_ceil(T_HZ_PS, CLK_PS),
    parameter int RC_CYC     = cyc_ceil(T_RC_PS, CLK_PS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int RD_LEN = max3(RD_ACC_CYC, OE_ACC_CYC, RC_CYC);
    localparam int WR_LEN = max3(WP_CYC, DS_CYC, RC_CYC);
    localparam int CNT_W  = $clog2(max3(RD_LEN, WR_LEN, TURN_CYC) + 1) + 1;

    seq_state_t       nxt_state;
    logic             accept;
    logic             ld_phase;
    logic [CNT_W-1:0] ld_val;
    logic             rd_done;
    logic             phase_done;
    logic             turn_clear;

    sram_seq_fsm #(
        .CNT_W (CNT_W),
        .RD_LEN(RD_LEN),
        .WR_LEN(WR_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .phase_done(phase_done),
        .turn_clear(turn_clear),
        .nxt_state (nxt_state),
        .accept    (accept),
        .ld_phase  (ld_phase),
        .ld_val    (ld_val),
        .rd_done   (rd_done)
    );

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_phase),
        .load_val(ld_val),
        .done    (phase_done)
    );

    sram_turn_guard #(
        .CNT_W   (CNT_W),
        .TURN_CYC(TURN_CYC)
    ) u_turn (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_end(rd_done),
        .clear (turn_clear)
    );

    sram_pin_drv u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_state(nxt_state),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .dq_oe    (sram_dq_oe),
        .ready    (req_ready)
    );

    sram_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .capture  (rd_done),
        .dq_in    (sram_dq_in),
        .addr     (sram_addr),
        .dq_out   (sram_dq_out),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Checker: timing properties at the memory pins and the host handshake
// of sram_async_ctrl. Run lengths and gaps are measured with saturating
// counters, so no property depth depends on a parameter.
module sram_async_ctrl_chk #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int RD_LEN   = 3,
    parameter int WR_LEN   = 3,
    parameter int TURN_CYC = 3,
    parameter int RC_CYC   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);

    logic [7:0] oe_low_run;
    logic [7:0] we_low_run;
    logic [7:0] since_oe_hi;
    logic [7:0] since_acc;

    // Length of the current output-enable-low run.
    always_ff @(posedge clk) begin
        if (!rst_n)          oe_low_run <= '0;
        else if (!sram_oe_n) oe_low_run <= (oe_low_run == 8'hFF) ? oe_low_run : oe_low_run + 8'd1;
        else                 oe_low_run <= '0;
    end

    // Length of the current write-strobe-low run.
    always_ff @(posedge clk) begin
        if (!rst_n)          we_low_run <= '0;
        else if (!sram_we_n) we_low_run <= (we_low_run == 8'hFF) ? we_low_run : we_low_run + 8'd1;
        else                 we_low_run <= '0;
    end

    // Cycles since output enable was last low (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_oe_hi <= 8'hFF;
        else if (!sram_oe_n)        since_oe_hi <= '0;
        else if (since_oe_hi != 8'hFF) since_oe_hi <= since_oe_hi + 8'd1;
    end

    // Cycles since the last accepted request (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_acc <= 8'hFF;
        else if (req_valid && req_ready) since_acc <= 8'd1;
        else if (since_acc != 8'hFF)   since_acc <= since_acc + 8'd1;
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

    // R6
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n && !sram_ce_n && sram_oe_n));

    // R7
    wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3
    rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_low_run == 8'(RD_LEN)));

    // R5
    wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_run == 8'(WR_LEN)));

    // R9
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (since_oe_hi >= 8'(TURN_CYC)));

    // R8
    acc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (since_acc >= 8'(RC_CYC + 1)));

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RD_LEN  (RD_LEN),
    .WR_LEN  (WR_LEN),
    .TURN_CYC(TURN_CYC),
    .RC_CYC  (RC_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_addr  (sram_addr),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard for sram_async_ctrl with a cycle-counting memory model.
module sram_async_ctrl_tb;

    // Expected counts at a 4 ns clock, worked out by hand from the limits.
    localparam int RD_LEN = 3;   // max(12/4, 6/4 -> 2, 12/4)
    localparam int WR_LEN = 3;   // max(10/4 -> 3, 7/4 -> 2, 3)
    localparam int ACC_C  = 3;   // access count
    localparam int DS_C   = 2;   // data setup count
    localparam int TURN   = 3;   // 9/4 -> 3
    localparam int RC     = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        ce_n, oe_n, we_n, dq_oe;
    logic [14:0] maddr;
    logic [7:0]  dq_out, dq_in;

    always #2 clk = ~clk;

    sram_async_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
        .sram_addr(maddr), .sram_dq_out(dq_out), .sram_dq_oe(dq_oe),
        .sram_dq_in(dq_in)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem     [int];
    logic [7:0] ref_mem [int];
    logic       mem_drv = 1'b0;
    logic [7:0] mem_q   = 8'h00;

    assign dq_in = dq_oe ? dq_out : (mem_drv ? mem_q : 8'hFF);

    function automatic logic [7:0] mrd(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    int   rd_cnt = 0, wr_cnt = 0, ds_cnt = 0, rel_cnt = 0;
    int   rd_addr = 0, wr_addr = 0;
    logic [7:0] wr_data = 8'h00;
    bit   rd_prev = 0, wr_prev = 0, oe_prev = 0;
    int   last_oe_low = -100;
    int   last_acc = -100;
    int   bus_fault = 0, idle_fault = 0, pulse_fault = 0;
    bit   rsp_prev = 0;

    // Model: observe the pins mid-cycle and decide what the memory drives.
    always @(negedge clk) begin
        bit reading, writing;
        if (rst_n) begin
            reading = !ce_n && !oe_n && we_n;
            writing = !ce_n && !we_n;
            if (reading) begin
                if (rd_prev && int'(maddr) == rd_addr) rd_cnt++;
                else begin rd_cnt = 1; rd_addr = int'(maddr); end
                rel_cnt = 0;
            end else if (rd_prev) begin
                chk(rd_cnt == RD_LEN, "R3 read strobe length", rd_cnt, RD_LEN);
                rel_cnt = TURN - 1;
            end else if (rel_cnt > 0) rel_cnt--;
            mem_drv = reading || (rel_cnt > 0);
            mem_q   = (reading && rd_cnt >= ACC_C) ? mrd(int'(maddr)) : ~mrd(int'(maddr));
            if (writing) begin
                if (oe_n == 1'b0) bus_fault++;
                if (wr_prev) begin
                    wr_cnt++;
                    if (int'(maddr) != wr_addr) bus_fault++;
                    if (dq_oe && dq_out == wr_data) ds_cnt++;
                    else begin ds_cnt = dq_oe ? 1 : 0; wr_data = dq_out; end
                end else begin
                    wr_cnt = 1; wr_addr = int'(maddr);
                    ds_cnt = dq_oe ? 1 : 0; wr_data = dq_out;
                end
            end else if (wr_prev) begin
                chk(wr_cnt == WR_LEN, "R5 write strobe length", wr_cnt, WR_LEN);
                chk(ds_cnt >= DS_C, "R7 data setup cycles", ds_cnt, DS_C);
                mem[wr_addr] = wr_data;
            end
            if (dq_oe && mem_drv) bus_fault++;             // R6 contention
            if (dq_oe && (we_n || ce_n || !oe_n)) bus_fault++;
            if (req_ready && (!ce_n || !oe_n || !we_n || dq_oe)) idle_fault++;
            if (dq_oe && !oe_prev) begin
                int e;
                e = (last_acc + 1 > last_oe_low + 1 + TURN) ? last_acc + 1 : last_oe_low + 1 + TURN;
                chk(cyc == e, "R9 write drive start cycle", cyc, e);
            end
            if (!oe_n) last_oe_low = cyc;
            rd_prev = reading; wr_prev = writing; oe_prev = dq_oe;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { int addr; logic [7:0] data; int acc; } exp_t;
    exp_t exp_q[$];

    // Monitor: pop an expected read for every response strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && rsp_prev) pulse_fault++;
            if (rsp_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected response", 1, 0);
                else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk(rsp_rdata == it.data, "R4 read data", rsp_rdata, it.data);
                    chk(cyc - it.acc == RD_LEN + 1, "R3 response latency", cyc - it.acc, RD_LEN + 1);
                end
            end
            rsp_prev = rsp_valid;
        end
    end

    // Driver: present one request, record expectations at acceptance.
    task automatic issue(input bit wr, input int a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 15'(a); req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (last_acc >= 0)
            chk(cyc - last_acc >= RC + 1, "R8 acceptance spacing", cyc - last_acc, RC + 1);
        last_acc = cyc;
        if (wr) ref_mem[a] = d;
        else begin
            exp_t it;
            it.addr = a;
            it.data = ref_mem.exists(a) ? ref_mem[a] : 8'h00;
            it.acc  = cyc;
            exp_q.push_back(it);
        end
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(ce_n && oe_n && we_n && !dq_oe && req_ready && !rsp_valid,
            "R1 state under reset", {ce_n, oe_n, we_n, dq_oe, req_ready}, 5'b11101);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n && oe_n && we_n && !dq_oe && req_ready && !rsp_valid,
            "R1 state after release", {ce_n, oe_n, we_n, dq_oe, req_ready}, 5'b11101);

        // Isolated writes at the extremes and with edge patterns (R5, R7).
        issue(1, 0, 8'hA5);
        issue(1, 15'h7FFF, 8'h3C);
        issue(1, 15'h1234, 8'h00);
        issue(1, 15'h1235, 8'hFF);
        issue(0, 0, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h1234, 8'h00);
        issue(0, 15'h1235, 8'h00);
        issue(0, 15'h0042, 8'h00);                 // never written (R4)
        // Read then write to the same address: turnaround delay (R9).
        issue(0, 15'h1234, 8'h00);
        issue(1, 15'h1234, 8'h77);
        issue(0, 15'h1234, 8'h00);
        // Burst of writes, then reads in reverse order.
        for (int i = 0; i < 16; i++) issue(1, (i * 15'h0801) & 15'h7FFF, 8'((i * 17) ^ 8'h55));
        for (int i = 15; i >= 0; i--) issue(0, (i * 15'h0801) & 15'h7FFF, 8'h00);
        // Alternating read / write / read.
        for (int i = 0; i < 8; i++) begin
            int a;
            a = (i * 15'h0801) & 15'h7FFF;
            issue(0, a, 8'h00);
            issue(1, a, 8'(~(i * 33)));
            issue(0, a, 8'h00);
        end
        // Write after a long idle: drive starts the cycle after acceptance.
        repeat (10) @(negedge clk);
        issue(1, 15'h0100, 8'h5A);
        issue(0, 15'h0100, 8'h00);

        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(bus_fault == 0, "R6 bus drive window", bus_fault, 0);
        chk(idle_fault == 0, "R2 deselected while ready", idle_fault, 0);
        chk(pulse_fault == 0, "R4 single-cycle response", pulse_fault, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule